// File: doc/BRIEF.md
# Multidrop Address-Detect Receive Filter

This block sits between the character-complete output of a serial receiver and the receive holding register with its interrupt. Each completed character is nine bits wide. The most significant bit marks a character as an address. In a multidrop bus, a node that is not currently addressed sets the filter enable. While the enable is set, only address characters reach software. Software compares the delivered address with its own. On a match, it clears the enable, and all later traffic then passes through unfiltered.

The filter makes no address comparison of its own. Its decision depends only on the top bit and the enable bit. Accepted characters are written into a single holding register. Accepting a character raises a data-valid flag and a sticky receive interrupt. A read strobe from software empties the register. An overrun flag records that an accepted character replaced data that had not been read. A dropped character does not count as an overrun.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, the enable bit, data-valid flag, interrupt and overrun flag are all 0, and the held data is 0.
- R2: With the enable bit at 0, every character presented with `char_valid` appears on `rx_data` in the cycle after its strobe, with `rx_valid` and `rx_irq` at 1.
- R3: With the enable bit at 1, a character whose bit 8 is 0 is dropped: `rx_data`, `rx_valid` and `rx_irq` keep their previous values.
- R4: With the enable bit at 1, a character whose bit 8 is 1 is delivered exactly as in R2.
- R5: A pulse on `en_wr` loads `en_wdata` into the enable bit, which is visible on `addr_det_en` from the next cycle. After software writes 0, all later characters are delivered.
- R6: A dropped character never sets `rx_ovr` and never overwrites data that has not been read.
- R7: `rx_irq` stays at 1 until a pulse on `data_rd`. That pulse clears `rx_valid`, `rx_irq` and `rx_ovr` in the next cycle, unless a character is accepted in the same cycle.
- R8: An accepted character that arrives while `rx_valid` is 1 and no read is pending replaces the data and sets `rx_ovr`. If a read arrives in the same cycle as the character, the new data is held, `rx_valid` stays at 1, and `rx_ovr` is 0.
- R9: A write to the enable bit in the same cycle as a character strobe does not affect that character. The character is judged by the enable value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a received character is complete |
| char_data | input | 9 | Received character; bit 8 marks an address |
| en_wr | input | 1 | Software write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| data_rd | input | 1 | Software read of the holding register |
| addr_det_en | output | 1 | Current enable bit |
| rx_data | output | 9 | Held character |
| rx_valid | output | 1 | Holding register contains unread data |
| rx_irq | output | 1 | Sticky receive interrupt |
| rx_ovr | output | 1 | Unread data was overwritten |

## Verification
Several properties are checked by assertions on every cycle. A dropped character leaves the held data, the valid flag and the overrun flag untouched. An address character, or any character while filtering is off, lands in the register one cycle later. A lone read empties the register. Other behaviour only the bench can show. It sweeps all 512 character values with the filter off and on, and leaves some characters unread so that overruns build up. It also covers an enable write colliding with a strobe, and a read coinciding with an accept.

// File: rtl/rxf_pkg.sv
// Shared definitions for the address-detect receive filter.
// Assumes characters carry their address marker in the top bit.
package rxf_pkg;
    typedef enum logic {
        RXF_DROP = 1'b0,
        RXF_KEEP = 1'b1
    } rxf_verdict_e;
endpackage

// File: rtl/rxf_ctl.sv
// Holds the address-detect enable bit written by software.
// Assumes en_wr is a single-cycle strobe; reset value is 0.
module rxf_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    output logic en_q
);
    // Load the enable bit on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_wr)
            en_q <= en_wdata;
    end
endmodule

// File: rtl/rxf_gate.sv
// Decides whether a completed character is passed on or discarded.
// Assumes en_q is the registered enable so a same-cycle write is not seen.
module rxf_gate
    import rxf_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              en_q,
    output rxf_verdict_e      verdict,
    output logic              accept
);
    localparam int MARK_BIT = CHAR_W - 1;

    // Keep a character when filtering is off or it carries the address mark.
    always_comb begin
        verdict = (!en_q || char_data[MARK_BIT]) ? RXF_KEEP : RXF_DROP;
        accept  = char_valid && (verdict == RXF_KEEP);
    end
endmodule

// File: rtl/rxf_hold.sv
// Single-entry holding register with valid, sticky interrupt and overrun.
// Assumes accept and rd are single-cycle strobes; accept wins over rd.
module rxf_hold #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              rd,
    output logic [CHAR_W-1:0] data_q,
    output logic              valid_q,
    output logic              irq_q,
    output logic              ovr_q
);
    // Capture accepted data; a read empties the register and clears flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (accept) begin
            data_q  <= char_data;
            valid_q <= 1'b1;
            irq_q   <= 1'b1;
            ovr_q   <= rd ? 1'b0 : (ovr_q | valid_q);
        end else if (rd) begin
            valid_q <= 1'b0;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_addr_filter.sv
// Top of the multidrop receive filter: enable bit, gate and holding register.
// Assumes one character strobe per cycle at most; software matches addresses.
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              data_rd,
    output logic              addr_det_en,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_irq,
    output logic              rx_ovr
);
    logic         en_q;
    logic         accept;
    rxf_verdict_e verdict;

    rxf_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .en_q     (en_q)
    );

    rxf_gate #(.CHAR_W(CHAR_W)) u_gate (
        .char_valid (char_valid),
        .char_data  (char_data),
        .en_q       (en_q),
        .verdict    (verdict),
        .accept     (accept)
    );

    rxf_hold #(.CHAR_W(CHAR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .char_data (char_data),
        .rd        (data_rd),
        .data_q    (rx_data),
        .valid_q   (rx_valid),
        .irq_q     (rx_irq),
        .ovr_q     (rx_ovr)
    );

    assign addr_det_en = en_q;
endmodule

// File: rtl/rxf_addr_filter_chk.sv
// Port-level properties of the receive filter, bound to the top module.
module rxf_addr_filter_chk #(
    parameter int CHAR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_data,
    input logic              data_rd,
    input logic              addr_det_en,
    input logic [CHAR_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_irq,
    input logic              rx_ovr
);
    assert_drop_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_det_en && char_valid && !char_data[CHAR_W-1]) |=> $stable(rx_data));

    assert_drop_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_det_en && char_valid && !char_data[CHAR_W-1] && !rx_valid && !data_rd)
        |=> (!rx_valid && !rx_irq));

    assert_mark_delivered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_data[CHAR_W-1])
        |=> (rx_valid && rx_irq && rx_data == $past(char_data)));

    assert_open_delivered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_det_en && char_valid) |=> (rx_valid && rx_data == $past(char_data)));

    assert_drop_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_det_en && char_valid && !char_data[CHAR_W-1] && !data_rd)
        |=> $stable(rx_ovr));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !char_valid) |=> (!rx_valid && !rx_irq && !rx_ovr));
endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_valid  (char_valid),
    .char_data   (char_data),
    .data_rd     (data_rd),
    .addr_det_en (addr_det_en),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_irq      (rx_irq),
    .rx_ovr      (rx_ovr)
);

// File: tb/rxf_addr_filter_tb.sv
module rxf_addr_filter_tb;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         char_valid = 1'b0;
    logic [W-1:0] char_data = '0;
    logic         en_wr = 1'b0;
    logic         en_wdata = 1'b0;
    logic         data_rd = 1'b0;
    logic         addr_det_en;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         rx_irq;
    logic         rx_ovr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state tracked arithmetically.
    logic [W-1:0] m_data = '0;
    logic         m_valid = 1'b0;
    logic         m_ovr = 1'b0;
    logic         m_en = 1'b0;

    always #2 clk = ~clk;

    rxf_addr_filter #(.CHAR_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .en_wr(en_wr), .en_wdata(en_wdata), .data_rd(data_rd),
        .addr_det_en(addr_det_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_irq(rx_irq), .rx_ovr(rx_ovr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "rx_data", int'(rx_data), int'(m_data));
        chk(req, "rx_valid", int'(rx_valid), int'(m_valid));
        chk(req, "rx_irq", int'(rx_irq), int'(m_valid));
        chk(req, "rx_ovr", int'(rx_ovr), int'(m_ovr));
        chk(req, "addr_det_en", int'(addr_det_en), int'(m_en));
    endtask

    // Present one character and update the model; check after the edge.
    task automatic send(input logic [W-1:0] v);
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = v;
        @(negedge clk);
        char_valid = 1'b0;
        if (!m_en || v[W-1]) begin
            m_ovr   = m_valid;
            m_valid = 1'b1;
            m_data  = v;
        end
    endtask

    task automatic rd();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        m_valid = 1'b0;
        m_ovr   = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
        m_en = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 then R3/R4/R6: full sweep with filter off, then on.
        for (int e = 0; e < 2; e++) begin
            wr_en(e[0]);
            chk("R5", "addr_det_en readback", int'(addr_det_en), e);
            for (int v = 0; v < 512; v++) begin
                send(v[W-1:0]);
                check_all(e == 0 ? "R2" : (v >= 256 ? "R4" : "R3_R6"));
                if (v % 4 != 3) begin
                    rd();
                    check_all("R7");
                end
            end
        end

        // R5: clear the enable; a plain character now passes.
        rd();
        wr_en(1'b0);
        send(9'h055);
        check_all("R5");

        // R8: accept while unread sets overrun.
        send(9'h0AA);
        check_all("R8");
        chk("R8", "overrun set", int'(rx_ovr), 1);

        // R8: read coinciding with accept keeps new data, no overrun.
        @(negedge clk);
        char_valid = 1'b1; char_data = 9'h033; data_rd = 1'b1;
        @(negedge clk);
        char_valid = 1'b0; data_rd = 1'b0;
        m_data = 9'h033; m_valid = 1'b1; m_ovr = 1'b0;
        check_all("R8");

        // R9: enable write in the same cycle as a plain character.
        rd();
        @(negedge clk);
        char_valid = 1'b1; char_data = 9'h011; en_wr = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        char_valid = 1'b0; en_wr = 1'b0;
        m_en = 1'b1; m_data = 9'h011; m_valid = 1'b1;
        check_all("R9");
        rd();
        send(9'h022);
        check_all("R9");
        @(negedge clk);
        char_valid = 1'b1; char_data = 9'h044; en_wr = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        char_valid = 1'b0; en_wr = 1'b0;
        m_en = 1'b0;
        check_all("R9");

        // R7: interrupt stays until read.
        send(9'h166);
        repeat (4) @(negedge clk);
        check_all("R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule